// File: doc/BRIEF.md
# Tiled Text Character Generator

This block turns a grid of character cells into a stream of 4-bit colour indices for a 1-bit-per-pixel text display. A timing generator issues a frame start and a line start. For each line, the block reads 16-bit cell words from a cell memory, one word per character. The high byte of each word is a colour attribute and the low byte is a glyph number. For each glyph the block reads one 16-bit word of font data. That word holds two glyph rows, and the block picks the row that belongs to the current line. It then sends out one pixel per clock, leftmost pixel first, and raises a valid flag on each of those clocks.

Both memories have a fixed read latency of one cycle. At the start of each line the block fetches one cell before it shows anything. It then fetches each following cell while the current cell is being shown. Horizontal fine scroll throws away the first pixels of the line. Vertical fine scroll sets which glyph row the frame starts on. In horizontal doubling mode each glyph bit is shown for two clocks, and the scroll range doubles so that the picture can still move by one output pixel. The font memory holds 4096 words in four banks. A short font (8 rows) uses one bank, and a tall font (16 rows) uses an aligned pair of banks.

The controller is a state machine with five states:
- S_IDLE waits for a line start. An accepted line start with a non-zero length moves it to S_CELL.
- S_CELL presents the address of the first cell and always moves to S_GLYPH.
- S_GLYPH captures the attribute and presents the font address, then always moves to S_LOAD.
- S_LOAD loads the first glyph row and always moves to S_SHOW.
- S_SHOW sends out pixels and fetches the next cell. It returns to S_IDLE once the last pixel of the line has gone out.

Top module: `tiled_text_gen`

## Requirements
- R1: After reset, `pix_valid` is low and stays low until a line is started.
- R2: A line with length L sends exactly L*8 valid pixels, or L*16 when `cfg_hdouble` is set. Pixels go out one per clock and most significant glyph bit first.
- R3: The cell word carries the attribute in bits 15:8 and the glyph number in bits 7:0. A glyph bit of 1 gives attribute bits 3:0 (foreground), and a 0 gives attribute bits 7:4 (background).
- R4: With a short font (`cfg_tall`=0) the font word address is {cfg_bank, glyph, row[2:1]}. Bits 15:8 of that word hold the even row and bits 7:0 hold the odd row.
- R5: With a tall font (`cfg_tall`=1) the font word address is {cfg_bank[1], glyph, row[3:1]}, so the font spans two neighbouring banks. Bit 0 of `cfg_bank` is ignored. The byte selection is the same as in R4.
- R6: `frame_go` sets the row base to `cfg_start_addr` and the glyph row to `cfg_vscroll`. Bit 3 of `cfg_vscroll` is ignored for short fonts. Each accepted line start advances the glyph row by one. After row 7 (short font) or row 15 (tall font) the glyph row wraps to 0 and the row base grows by `cfg_line_len`.
- R7: Without doubling, the first `cfg_hscroll[2:0]` pixels of the line are dropped and bit 3 of `cfg_hscroll` is ignored. The next pixels of the following cell complete the line.
- R8: With doubling, each glyph bit covers two output pixels and all four bits of `cfg_hscroll` (0..15) count dropped output pixels.
- R9: Each line starts from its own first cell, with no data left over from the previous line. No pixel is valid in the first two cycles of a line. While a line runs, the cell address only ever steps up by one.
- R10: A line start with `cfg_line_len`=0 sends no pixels but still advances the glyph row.
- R11: A line start that arrives while a line is in progress is ignored and does not advance the glyph row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame start pulse |
| line_go | input | 1 | Line start pulse |
| cfg_start_addr | input | ADDR_W | Cell address of the top-left character |
| cfg_line_len | input | COL_W | Characters per line; also the row stride |
| cfg_tall | input | 1 | 1: 16-row glyphs, 0: 8-row glyphs |
| cfg_bank | input | 2 | Font bank select |
| cfg_hscroll | input | 4 | Horizontal fine scroll in output pixels |
| cfg_vscroll | input | 4 | Starting glyph row of the frame |
| cfg_hdouble | input | 1 | Horizontal pixel doubling |
| cell_addr | output | ADDR_W | Cell memory word address |
| cell_rdata | input | 16 | Cell word, one cycle after its address |
| font_addr | output | 12 | Font memory word address |
| font_rdata | input | 16 | Font word, one cycle after its address |
| pix_valid | output | 1 | Pixel valid |
| pix_color | output | 4 | Pixel colour index |

## Verification
The assertions assume four things about the inputs:
- `frame_go` never arrives in the same cycle as `line_go`.
- `frame_go` never arrives while a line is in progress.
- The configuration inputs stay constant while a line is in progress.
- Each memory returns the word for the address it held one cycle earlier.

The stimulus respects all four. It changes the configuration and pulses `frame_go` only between lines, after the previous line has had time to finish. It models both memories as registered functions of the address. The one overlapping `line_go` pulse is sent on purpose, to check that a line start arriving mid-line is ignored.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    localparam int FONT_AW = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CELL,
        S_GLYPH,
        S_LOAD,
        S_SHOW
    } tcg_state_e;

    // Font word address: short glyphs use one 1K-word bank, tall glyphs an aligned pair.
    function automatic logic [FONT_AW-1:0] font_word_addr(
        input logic [7:0] glyph,
        input logic [3:0] row,
        input logic       tall,
        input logic [1:0] bank
    );
        if (tall) begin
            return {bank[1], glyph, row[3:1]};
        end
        return {bank, glyph, row[2:1]};
    endfunction

endpackage

// File: rtl/tcg_row_track.sv
module tcg_row_track #(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              line_take,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [COL_W-1:0]  cfg_line_len,
    input  logic              cfg_tall,
    input  logic [3:0]        cfg_vscroll,
    output logic [ADDR_W-1:0] line_addr,
    output logic [3:0]        line_row
);

    logic [3:0] last_row;

    assign last_row = cfg_tall ? 4'd15 : 4'd7;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            line_row  <= '0;
        end else if (frame_go) begin
            line_addr <= cfg_start_addr;
            line_row  <= cfg_tall ? cfg_vscroll : {1'b0, cfg_vscroll[2:0]};
        end else if (line_take) begin
            if (line_row == last_row) begin
                line_row  <= '0;
                line_addr <= line_addr + ADDR_W'(cfg_line_len);
            end else begin
                line_row <= line_row + 4'd1;
            end
        end
    end

endmodule

// File: rtl/tcg_line_fsm.sv
module tcg_line_fsm
    import tcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_go,
    input  logic [ADDR_W-1:0]  line_addr,
    input  logic [3:0]         line_row,
    input  logic [COL_W-1:0]   cfg_line_len,
    input  logic               cfg_tall,
    input  logic [1:0]         cfg_bank,
    input  logic [3:0]         cfg_hscroll,
    input  logic               cfg_hdouble,
    input  logic [15:0]        cell_rdata,
    input  logic [15:0]        font_rdata,
    output logic               line_take,
    output logic               busy,
    output logic [ADDR_W-1:0]  cell_addr,
    output logic [FONT_AW-1:0] font_addr,
    output logic               show_en,
    output logic [7:0]         cur_bits,
    output logic [7:0]         cur_attr,
    output logic [2:0]         bit_idx
);

    localparam int REM_W = COL_W + 4;

    tcg_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        row_q;
    logic              dbl_q;
    logic [3:0]        sub_q;
    logic [3:0]        skip_q;
    logic [REM_W-1:0]  remain_q;
    logic [7:0]        pend_attr_q;
    logic [7:0]        nxt_bits_q, nxt_attr_q;
    logic [7:0]        cur_bits_q, cur_attr_q;
    logic [3:0]        sub_last;
    logic [7:0]        font_byte;

    assign sub_last  = dbl_q ? 4'd15 : 4'd7;
    assign font_byte = row_q[0] ? font_rdata[7:0] : font_rdata[15:8];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (line_go && cfg_line_len != '0) state_d = S_CELL;
            S_CELL:  state_d = S_GLYPH;
            S_GLYPH: state_d = S_LOAD;
            S_LOAD:  state_d = S_SHOW;
            S_SHOW:  if (skip_q == '0 && remain_q == REM_W'(1)) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        line_take = (state_q == S_IDLE) && line_go;
        busy      = (state_q != S_IDLE);
        show_en   = (state_q == S_SHOW) && (skip_q == '0);
        cell_addr = addr_q;
        font_addr = font_word_addr(cell_rdata[7:0], row_q, cfg_tall, cfg_bank);
        cur_bits  = cur_bits_q;
        cur_attr  = cur_attr_q;
        bit_idx   = dbl_q ? sub_q[3:1] : sub_q[2:0];
    end

    // Fetch and count datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            row_q       <= '0;
            dbl_q       <= 1'b0;
            sub_q       <= '0;
            skip_q      <= '0;
            remain_q    <= '0;
            pend_attr_q <= '0;
            nxt_bits_q  <= '0;
            nxt_attr_q  <= '0;
            cur_bits_q  <= '0;
            cur_attr_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (line_take) begin
                        addr_q   <= line_addr;
                        row_q    <= line_row;
                        dbl_q    <= cfg_hdouble;
                        sub_q    <= '0;
                        skip_q   <= cfg_hdouble ? cfg_hscroll : {1'b0, cfg_hscroll[2:0]};
                        remain_q <= cfg_hdouble ? {cfg_line_len, 4'b0000}
                                                : {1'b0, cfg_line_len, 3'b000};
                    end
                end
                S_CELL: begin
                end
                S_GLYPH: begin
                    pend_attr_q <= cell_rdata[15:8];
                end
                S_LOAD: begin
                    cur_bits_q <= font_byte;
                    cur_attr_q <= pend_attr_q;
                    addr_q     <= addr_q + ADDR_W'(1);
                end
                S_SHOW: begin
                    if (sub_q == 4'd1) begin
                        pend_attr_q <= cell_rdata[15:8];
                    end
                    if (sub_q == 4'd2) begin
                        nxt_bits_q <= font_byte;
                        nxt_attr_q <= pend_attr_q;
                    end
                    if (sub_q == sub_last) begin
                        sub_q      <= '0;
                        cur_bits_q <= nxt_bits_q;
                        cur_attr_q <= nxt_attr_q;
                        addr_q     <= addr_q + ADDR_W'(1);
                    end else begin
                        sub_q <= sub_q + 4'd1;
                    end
                    if (skip_q != '0) begin
                        skip_q <= skip_q - 4'd1;
                    end else begin
                        remain_q <= remain_q - REM_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/tcg_pixel_out.sv
module tcg_pixel_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       show_en,
    input  logic [7:0] cur_bits,
    input  logic [7:0] cur_attr,
    input  logic [2:0] bit_idx,
    output logic       pix_valid,
    output logic [3:0] pix_color
);

    logic lit;

    assign lit = cur_bits[3'd7 - bit_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_color <= '0;
        end else begin
            pix_valid <= show_en;
            pix_color <= lit ? cur_attr[3:0] : cur_attr[7:4];
        end
    end

endmodule

// File: rtl/tiled_text_gen.sv
module tiled_text_gen
    import tcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_go,
    input  logic               line_go,
    input  logic [ADDR_W-1:0]  cfg_start_addr,
    input  logic [COL_W-1:0]   cfg_line_len,
    input  logic               cfg_tall,
    input  logic [1:0]         cfg_bank,
    input  logic [3:0]         cfg_hscroll,
    input  logic [3:0]         cfg_vscroll,
    input  logic               cfg_hdouble,
    output logic [ADDR_W-1:0]  cell_addr,
    input  logic [15:0]        cell_rdata,
    output logic [FONT_AW-1:0] font_addr,
    input  logic [15:0]        font_rdata,
    output logic               pix_valid,
    output logic [3:0]         pix_color
);

    logic              line_take;
    logic              busy;
    logic [ADDR_W-1:0] line_addr;
    logic [3:0]        line_row;
    logic              show_en;
    logic [7:0]        cur_bits, cur_attr;
    logic [2:0]        bit_idx;

    tcg_row_track #(.ADDR_W(ADDR_W), .COL_W(COL_W)) i_rows (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_go      (frame_go),
        .line_take     (line_take),
        .cfg_start_addr(cfg_start_addr),
        .cfg_line_len  (cfg_line_len),
        .cfg_tall      (cfg_tall),
        .cfg_vscroll   (cfg_vscroll),
        .line_addr     (line_addr),
        .line_row      (line_row)
    );

    tcg_line_fsm #(.ADDR_W(ADDR_W), .COL_W(COL_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_go     (line_go),
        .line_addr   (line_addr),
        .line_row    (line_row),
        .cfg_line_len(cfg_line_len),
        .cfg_tall    (cfg_tall),
        .cfg_bank    (cfg_bank),
        .cfg_hscroll (cfg_hscroll),
        .cfg_hdouble (cfg_hdouble),
        .cell_rdata  (cell_rdata),
        .font_rdata  (font_rdata),
        .line_take   (line_take),
        .busy        (busy),
        .cell_addr   (cell_addr),
        .font_addr   (font_addr),
        .show_en     (show_en),
        .cur_bits    (cur_bits),
        .cur_attr    (cur_attr),
        .bit_idx     (bit_idx)
    );

    tcg_pixel_out i_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .show_en  (show_en),
        .cur_bits (cur_bits),
        .cur_attr (cur_attr),
        .bit_idx  (bit_idx),
        .pix_valid(pix_valid),
        .pix_color(pix_color)
    );

endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_go,
    input logic              line_go,
    input logic              busy,
    input logic              pix_valid,
    input logic [ADDR_W-1:0] cell_addr,
    input logic [ADDR_W-1:0] line_addr,
    input logic [11:0]       font_addr,
    input logic              cfg_tall,
    input logic [1:0]        cfg_bank
);

    // R2: a valid pixel is always produced by a line in progress
    a_r2_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(busy));

    // R9: the prefetch keeps the first cycles of a line free of pixels
    a_r9_prefetch_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !pix_valid);

    // R9: within a line the cell address only steps forward by one
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cell_addr != $past(cell_addr))
            |-> cell_addr == $past(cell_addr) + ADDR_W'(1));

    // R4: short glyphs stay inside the selected bank
    a_r4_bank_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tall |-> font_addr[11:10] == cfg_bank);

    // R5: tall glyphs stay inside the selected bank pair
    a_r5_bank_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tall |-> font_addr[11] == cfg_bank[1]);

    // R11: a line start during a running line leaves the row state alone
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_go && !frame_go) |=> $stable(line_addr));

endmodule

bind tiled_text_gen tcg_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .line_go  (line_go),
    .busy     (busy),
    .pix_valid(pix_valid),
    .cell_addr(cell_addr),
    .line_addr(line_addr),
    .font_addr(font_addr),
    .cfg_tall (cfg_tall),
    .cfg_bank (cfg_bank)
);

// File: tb/test_tiled_text_gen.sv
module test_tiled_text_gen;

    localparam int ADDR_W = 16;
    localparam int COL_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_go = 1'b0;
    logic              line_go = 1'b0;
    logic [ADDR_W-1:0] cfg_start_addr = '0;
    logic [COL_W-1:0]  cfg_line_len = '0;
    logic              cfg_tall = 1'b0;
    logic [1:0]        cfg_bank = '0;
    logic [3:0]        cfg_hscroll = '0;
    logic [3:0]        cfg_vscroll = '0;
    logic              cfg_hdouble = 1'b0;
    logic [ADDR_W-1:0] cell_addr;
    logic [15:0]       cell_rdata = '0;
    logic [11:0]       font_addr;
    logic [15:0]       font_rdata = '0;
    logic              pix_valid;
    logic [3:0]        pix_color;

    always #10 clk = ~clk;

    tiled_text_gen #(.ADDR_W(ADDR_W), .COL_W(COL_W)) i_tiled_text_gen (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .line_go(line_go),
        .cfg_start_addr(cfg_start_addr), .cfg_line_len(cfg_line_len),
        .cfg_tall(cfg_tall), .cfg_bank(cfg_bank), .cfg_hscroll(cfg_hscroll),
        .cfg_vscroll(cfg_vscroll), .cfg_hdouble(cfg_hdouble),
        .cell_addr(cell_addr), .cell_rdata(cell_rdata),
        .font_addr(font_addr), .font_rdata(font_rdata),
        .pix_valid(pix_valid), .pix_color(pix_color)
    );

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [ADDR_W-1:0] m_base;
    logic [3:0]        m_row;

    function automatic logic [15:0] cell_fn(input logic [ADDR_W-1:0] a);
        logic [7:0] at = 8'(a * 37 + 3);
        logic [7:0] gl = 8'(a * 13 + 7);
        return {at, gl};
    endfunction

    function automatic logic [15:0] font_fn(input logic [11:0] w);
        logic [15:0] x = 16'(w) * 16'h9E37;
        return x ^ {4'h0, w};
    endfunction

    // Memory models with one cycle of read latency
    always @(posedge clk) begin
        cell_rdata <= cell_fn(cell_addr);
        font_rdata <= font_fn(font_addr);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each valid pixel against the scoreboard
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected pixel", int'(pix_color), -1);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pix_color == e, t, "pixel colour", int'(pix_color), int'(e));
            end
        end
    end

    task automatic set_frame(input logic [ADDR_W-1:0] start, input int len,
                             input bit tall, input int bank, input int hs,
                             input int vs, input bit dbl);
        @(negedge clk);
        cfg_start_addr = start;
        cfg_line_len   = COL_W'(len);
        cfg_tall       = tall;
        cfg_bank       = 2'(bank);
        cfg_hscroll    = 4'(hs);
        cfg_vscroll    = 4'(vs);
        cfg_hdouble    = dbl;
        frame_go       = 1'b1;
        @(negedge clk);
        frame_go = 1'b0;
        m_base = start;
        m_row  = tall ? 4'(vs) : {1'b0, 3'(vs)};
    endtask

    // Driver: push expected pixels of one line and advance the model row
    task automatic push_line(input string tag);
        int cw    = cfg_hdouble ? 16 : 8;
        int heff  = cfg_hdouble ? int'(cfg_hscroll) : int'(cfg_hscroll[2:0]);
        int width = int'(cfg_line_len) * cw;
        for (int p = 0; p < width; p++) begin
            int q = p + heff;
            int bidx = (q % cw) / (cfg_hdouble ? 2 : 1);
            logic [15:0] cw_word = cell_fn(m_base + ADDR_W'(q / cw));
            logic [11:0] fa = cfg_tall ? {cfg_bank[1], cw_word[7:0], m_row[3:1]}
                                       : {cfg_bank, cw_word[7:0], m_row[2:1]};
            logic [15:0] fw = font_fn(fa);
            logic [7:0]  by = m_row[0] ? fw[7:0] : fw[15:8];
            exp_q.push_back(by[7 - bidx] ? cw_word[11:8] : cw_word[15:12]);
            tag_q.push_back(tag);
        end
        if (m_row == (cfg_tall ? 4'd15 : 4'd7)) begin
            m_row  = '0;
            m_base = m_base + ADDR_W'(cfg_line_len);
        end else begin
            m_row = m_row + 4'd1;
        end
    endtask

    task automatic run_line(input string tag, input bit poke_mid);
        int cw = cfg_hdouble ? 16 : 8;
        push_line(tag);
        @(negedge clk);
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        if (poke_mid) begin
            repeat (6) @(negedge clk);
            line_go = 1'b1;
            @(negedge clk);
            line_go = 1'b0;
        end
        repeat (int'(cfg_line_len) * cw + 24) @(negedge clk);
        check(exp_q.size() == 0, tag, "pixels left at line end", exp_q.size(), 0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(pix_valid == 1'b0, "R1", "valid during reset", int'(pix_valid), 0);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check(pix_valid == 1'b0, "R1", "valid while idle", int'(pix_valid), 0);
        end

        // R2 R3 R4: short font, plain lines crossing a row wrap
        set_frame(16'h0040, 4, 1'b0, 1, 0, 5, 1'b0);
        for (int i = 0; i < 5; i++) run_line("R4", 1'b0);
        run_line("R3", 1'b0);

        // R5 R6: tall font, odd bank, vertical scroll past the row wrap
        set_frame(16'h0123, 3, 1'b1, 3, 0, 13, 1'b0);
        for (int i = 0; i < 6; i++) run_line("R5", 1'b0);
        run_line("R6", 1'b0);

        // R6: short font ignores vscroll bit 3
        set_frame(16'h0200, 2, 1'b0, 2, 0, 14, 1'b0);
        for (int i = 0; i < 3; i++) run_line("R6", 1'b0);

        // R7: horizontal scroll, bit 3 ignored without doubling
        set_frame(16'h0300, 5, 1'b0, 0, 5, 0, 1'b0);
        run_line("R7", 1'b0);
        run_line("R7", 1'b0);
        set_frame(16'h0310, 3, 1'b0, 0, 12, 3, 1'b0);
        run_line("R7", 1'b0);

        // R8: doubling with wide scroll values
        set_frame(16'h0400, 3, 1'b0, 1, 11, 2, 1'b1);
        run_line("R8", 1'b0);
        run_line("R8", 1'b0);
        set_frame(16'h0420, 2, 1'b1, 0, 15, 7, 1'b1);
        run_line("R8", 1'b0);
        set_frame(16'h0430, 2, 1'b0, 2, 0, 0, 1'b1);
        run_line("R8", 1'b0);

        // R9: back-to-back lines with different rows and content
        set_frame(16'h0500, 1, 1'b0, 3, 3, 0, 1'b0);
        run_line("R9", 1'b0);
        run_line("R9", 1'b0);

        // R10: zero length line sends nothing but advances the row
        set_frame(16'h0600, 0, 1'b0, 1, 0, 6, 1'b0);
        run_line("R10", 1'b0);
        @(negedge clk);
        cfg_line_len = COL_W'(2);
        run_line("R10", 1'b0);
        run_line("R10", 1'b0);

        // R11: a second line start during a line is ignored
        set_frame(16'h0700, 3, 1'b0, 0, 0, 2, 1'b0);
        run_line("R11", 1'b1);
        run_line("R11", 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule